// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Coherent Readout

This block keeps a 12-bit count that steps once per microsecond, derived from a faster system clock through an internal divider. The count never stops and never takes a load; after 0xFFF it rolls back to 0x000 and raises no flag. Software measures an interval by taking two readings and subtracting them modulo 4096. The difference is the elapsed time in microseconds.

Software reads the count over an 8-bit path in two pieces. A strobe for the low byte returns bits 7:0 and, in the same clock, copies bits 11:8 into a holding register. A later strobe for the upper piece returns that held nibble rather than the live count. A low-then-high read sequence therefore always yields one consistent 12-bit value, even if the count carries between the two reads. Read results appear one cycle after the strobe, qualified by a valid pulse. The path has no back-pressure: every strobe is answered in the next cycle.

The block also drives two tick pulses for an interrupt controller. One fires every 128 µs, when count bit 6 goes from 0 to 1. The other fires every 1024 µs, when count bit 9 goes from 0 to 1.

Top module: `usec_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it, rd_valid, tick_fast, tick_slow and rd_data are all 0 and the count is 0.
- R2: With DIV = 12, the count after E rising clock edges following reset release equals floor(E/12) mod 4096.
- R3: The count wraps from 0xFFF to 0x000 and keeps running.
- R4: A strobe on rd_lo_stb in cycle N gives rd_valid = 1 in cycle N+1, with rd_data = count bits 7:0 as held during cycle N. rd_valid is 0 in any cycle that follows a cycle with no strobe.
- R5: A low-byte strobe copies count bits 11:8 into the holding register in the same clock edge that captures the low byte.
- R6: A strobe on rd_hi_stb alone gives rd_data = {4'b0000, holding register} in the next cycle. The live count does not affect this value, and the high strobe leaves the holding register unchanged.
- R7: If no low-byte read has happened since reset, a high read returns 0x00.
- R8: tick_fast is a one-cycle pulse, high in the first cycle in which count bit 6 has gone from 0 to 1, giving a period of 128 count steps.
- R9: tick_slow is a one-cycle pulse, high in the first cycle in which count bit 9 has gone from 0 to 1, giving a period of 1024 count steps.
- R10: If both strobes are high in the same cycle, the low-byte read takes priority: the next rd_data is the low byte and the holding register is updated.
- R11: A low read followed by a high read gives a 12-bit reading. The difference between two such readings, modulo 4096, equals the number of count steps between their low-byte strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 per count step by default) |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_lo_stb | input | 1 | Read strobe for count bits 7:0; also loads the holding register |
| rd_hi_stb | input | 1 | Read strobe for the held upper nibble |
| rd_data | output | 8 | Read result, registered, valid one cycle after a strobe |
| rd_valid | output | 1 | High for one cycle when rd_data carries a new read result |
| tick_fast | output | 1 | One-cycle pulse every 128 count steps |
| tick_slow | output | 1 | One-cycle pulse every 1024 count steps |

## Verification
The assertions assume that rst_n is synchronous and is held for at least one clock. They also assume a divider ratio above 1, so the count enable can never be high on two cycles in a row. The pulse-width properties depend on that. The strobes may take any value in any cycle. The stimulus changes strobes only at falling edges and uses single-cycle strobes, back-to-back low reads, lone high reads and simultaneous strobes. The run spans two full wraps of the count, so every tick position and the 0xFFF rollover are reached.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
  localparam int unsigned CNT_W_DEF   = 12;
  localparam int unsigned BUS_W_DEF   = 8;
  localparam int unsigned DIV_DEF     = 12;
  localparam int unsigned FAST_BIT_DEF = 6;
  localparam int unsigned SLOW_BIT_DEF = 9;
  localparam int unsigned NTICK       = 2;
  localparam int unsigned TICK_FAST   = 0;
  localparam int unsigned TICK_SLOW   = 1;
endpackage

// File: rtl/usec_prescale.sv
module usec_prescale #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic step_en
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign step_en = (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (step_en) phase <= '0;
    else              phase <= phase + PW'(1);
  end

  // R2: enable never lasts more than one cycle
  assert_en_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> !step_en);
endmodule

// File: rtl/usec_counter.sv
module usec_counter
  import usec_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned FAST_BIT = 6,
  parameter int unsigned SLOW_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  output logic [CNT_W-1:0] count,
  output logic [NTICK-1:0] ticks
);
  localparam int unsigned TBIT [NTICK] = '{FAST_BIT, SLOW_BIT};

  logic [CNT_W-1:0] count_nxt;
  assign count_nxt = count + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (step_en) count <= count_nxt;
  end

  for (genvar g = 0; g < NTICK; g++) begin : g_tick
    localparam logic [CNT_W-1:0] LOWM = CNT_W'((1 << (TBIT[g] + 1)) - 1);
    localparam logic [CNT_W-1:0] EDGEV = CNT_W'(1 << TBIT[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) ticks[g] <= 1'b0;
      else        ticks[g] <= step_en && !count[TBIT[g]] && count_nxt[TBIT[g]];
    end

    // R8 R9: a tick marks the first cycle after the watched bit rose
    assert_tick_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ticks[g] |-> ((count & LOWM) == EDGEV));
    assert_tick_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ticks[g] |=> !ticks[g]);
    assert_tick_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ticks[g] |-> $past(step_en));
  end

  // R2: one step per enable, frozen otherwise
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (count == $past(count) + CNT_W'(1)));
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(count));
  // R3: rollover to zero
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && (&count)) |=> (count == '0));
endmodule

// File: rtl/usec_read_latch.sv
module usec_read_latch #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_lo_stb,
  input  logic             rd_hi_stb,
  input  logic [CNT_W-1:0] count,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid
);
  localparam int unsigned HI_W  = CNT_W - BUS_W;
  localparam int unsigned PAD_W = BUS_W - HI_W;

  logic [HI_W-1:0] held_hi;
  logic [BUS_W-1:0] hi_word;

  assign hi_word = {{PAD_W{1'b0}}, held_hi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_hi  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_lo_stb | rd_hi_stb;
      if (rd_lo_stb) begin
        held_hi <= count[CNT_W-1:BUS_W];
        rd_data <= count[BUS_W-1:0];
      end else if (rd_hi_stb) begin
        rd_data <= hi_word;
      end
    end
  end

  // R5: low read snapshots the upper bits
  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_stb |=> (held_hi == $past(count[CNT_W-1:BUS_W])));
  // R6: nothing but a low read changes the snapshot
  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo_stb |=> $stable(held_hi));
  // R4: valid follows exactly one cycle after a strobe
  assert_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo_stb || rd_hi_stb) |=> rd_valid);
  assert_novalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_lo_stb || rd_hi_stb) |=> !rd_valid);
endmodule

// File: rtl/usec_timer.sv
module usec_timer
  import usec_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned BUS_W    = BUS_W_DEF,
  parameter int unsigned DIV      = DIV_DEF,
  parameter int unsigned FAST_BIT = FAST_BIT_DEF,
  parameter int unsigned SLOW_BIT = SLOW_BIT_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_lo_stb,
  input  logic             rd_hi_stb,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             tick_fast,
  output logic             tick_slow
);
  logic             step_en;
  logic [CNT_W-1:0] count;
  logic [NTICK-1:0] ticks;

  usec_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .step_en(step_en)
  );

  usec_counter #(.CNT_W(CNT_W), .FAST_BIT(FAST_BIT), .SLOW_BIT(SLOW_BIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .count(count), .ticks(ticks)
  );

  usec_read_latch #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_lo_stb(rd_lo_stb), .rd_hi_stb(rd_hi_stb),
    .count(count), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign tick_fast = ticks[TICK_FAST];
  assign tick_slow = ticks[TICK_SLOW];

  // R8 R9: the slow tick lands on a count where the fast bit is clear
  assert_tick_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_fast && tick_slow));
endmodule

// File: tb/sim_usec_timer.sv
module sim_usec_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NCYC = 99000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_lo_stb = 1'b0;
  logic rd_hi_stb = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid, tick_fast, tick_slow;

  int n_chk = 0;
  int n_fail = 0;
  int edges = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  usec_timer u0 (
    .clk(clk), .rst_n(rst_n), .rd_lo_stb(rd_lo_stb), .rd_hi_stb(rd_hi_stb),
    .rd_data(rd_data), .rd_valid(rd_valid), .tick_fast(tick_fast), .tick_slow(tick_slow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at edge %0d", tag, act, exp, edges);
    end
  endtask

  initial begin
    bit pend = 0;
    bit pend_lo = 0;
    bit pair_hi = 0;
    bit have_prev = 0;
    logic [7:0] exp_data = '0;
    logic [3:0] hold_m = '0;
    logic [7:0] lo_val = '0;
    int lo_step = 0;
    int prev_full = 0;
    int prev_step = 0;

    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R1 valid", rd_valid, 0);
    chk(tick_fast == 1'b0 && tick_slow == 1'b0, "R1 ticks", {tick_slow, tick_fast}, 0);
    chk(rd_data == 8'h00, "R1 data", rd_data, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NCYC; i++) begin
      int steps;
      logic [11:0] cur;
      int p;
      steps = edges / 12;
      cur = 12'(steps);
      p = i % 997;

      // read result from the previous cycle's strobe
      if (pend) begin
        chk(rd_valid == 1'b1, "R4 valid", rd_valid, 1);
        chk(rd_data == exp_data, pend_lo ? "R4 R2 R3 low byte" : "R6 R7 high nibble", rd_data, exp_data);
        if (pair_hi) begin
          int full;
          full = {rd_data[3:0], lo_val};
          chk(full == (lo_step % 4096), "R2 R3 R11 full reading", full, lo_step % 4096);
          if (have_prev)
            chk(((full - prev_full) & 12'hFFF) == ((lo_step - prev_step) % 4096),
                "R11 interval", (full - prev_full) & 12'hFFF, (lo_step - prev_step) % 4096);
          prev_full = full;
          prev_step = lo_step;
          have_prev = 1;
        end
      end else begin
        chk(rd_valid == 1'b0, "R4 idle", rd_valid, 0);
      end

      // ticks
      begin
        bit ef, es;
        ef = (edges > 0) && (edges % 12 == 0) && (cur % 128 == 64);
        es = (edges > 0) && (edges % 12 == 0) && (cur % 1024 == 512);
        chk(tick_fast == ef, "R8 tick_fast", tick_fast, ef);
        chk(tick_slow == es, "R9 tick_slow", tick_slow, es);
      end

      // next strobe
      pend = 0; pend_lo = 0; pair_hi = 0;
      rd_lo_stb = 1'b0; rd_hi_stb = 1'b0;
      if (i == 0) begin
        rd_hi_stb = 1'b1; exp_data = {4'h0, hold_m}; pend = 1;      // R7
      end else if (p == 5 || (p >= 700 && p <= 705)) begin
        rd_lo_stb = 1'b1; exp_data = cur[7:0]; hold_m = cur[11:8];  // R5
        lo_val = cur[7:0]; lo_step = steps; pend = 1; pend_lo = 1;
      end else if (p == 6 || p == 706) begin
        rd_hi_stb = 1'b1; exp_data = {4'h0, hold_m}; pend = 1; pair_hi = 1;
      end else if (p == 300) begin
        rd_hi_stb = 1'b1; exp_data = {4'h0, hold_m}; pend = 1;      // R6 stale
      end else if (p == 500) begin
        rd_lo_stb = 1'b1; rd_hi_stb = 1'b1;                         // R10
        exp_data = cur[7:0]; hold_m = cur[11:8];
        lo_val = cur[7:0]; lo_step = steps; pend = 1; pend_lo = 1;
      end else if (p == 501) begin
        rd_hi_stb = 1'b1; exp_data = {4'h0, hold_m}; pend = 1; pair_hi = 1; // R10 hold updated
      end
      @(negedge clk);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule